// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block controls how a small processor core leaves its low-power sleep state. It runs on the raw oscillator clock. It divides that clock into four-phase instruction cycles, and it moves between its states only at the boundary of an instruction cycle.

A rising edge on the external interrupt pin is first synchronised. It then sets an interrupt flag, and that flag wakes the core. On wake, a crystal-type oscillator mode holds the core clock gated for a fixed start-up count of oscillator periods. An RC or EC mode skips this wait.

After wake, the prefetched instruction executes during one resume cycle. If the global interrupt enable is set, fetch is then redirected to the interrupt vector and one dummy cycle follows. Otherwise execution continues in-line. A sleep request made while the flag is already set does not gate the clock. The core goes straight to the resume cycle.

Top module: `slp_wake_seq`

## Requirements
- R1: After reset, core_clk_en_o is 1 and pc_vec_sel_o, bubble_o and int_flag_o are 0.
- R2: A rising edge on int_pin_i, after a synchroniser of SYNC_STAGES flops, sets int_flag_o. The flag holds until int_clr_i is 1 on a clock without a new rising edge. A set and a clear in the same clock leave the flag set. A falling edge does not set the flag.
- R3: An instruction cycle is four oscillator clocks, counted from reset. When sleep_req_i is 1 at the end of a running cycle and int_flag_o is 0, core_clk_en_o goes to 0 at that boundary.
- R4: While asleep, int_flag_o is sampled at every cycle boundary. Sleep ends at the first boundary where the flag is 1, and not before.
- R5: If osc_xtal_i is 1 at the wake boundary, core_clk_en_o stays 0 for OST_CYCLES (default 1024) more oscillator periods. It goes to 1 exactly OST_CYCLES clocks after that boundary.
- R6: If osc_xtal_i is 0 at the wake boundary, core_clk_en_o goes to 1 at that boundary.
- R7: The resume cycle lasts exactly one instruction cycle with core_clk_en_o = 1 and bubble_o = 0. During it, pc_vec_sel_o (1 = fetch from the interrupt vector) equals gie_i as sampled at the boundary that started it.
- R8: With the enable latched at 1, the resume cycle is followed by exactly one dummy cycle with bubble_o = 1, pc_vec_sel_o = 0 and core_clk_en_o = 1. Normal running follows it.
- R9: With the enable latched at 0, normal running follows the resume cycle directly. bubble_o stays 0 and pc_vec_sel_o stays 0.
- R10: A sleep request at a boundary where int_flag_o is already 1 never drops core_clk_en_o. No start-up wait applies, even when osc_xtal_i is 1. The resume cycle starts at that boundary.
- R11: core_clk_en_o, pc_vec_sel_o and bubble_o change only on the clock edge that ends an instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request from the core, sampled at cycle end |
| int_pin_i | input | 1 | External interrupt pin, asynchronous |
| int_clr_i | input | 1 | Clears the interrupt flag |
| gie_i | input | 1 | Global interrupt enable |
| osc_xtal_i | input | 1 | 1 = crystal-type oscillator mode (needs start-up wait) |
| core_clk_en_o | output | 1 | Core clock enable |
| pc_vec_sel_o | output | 1 | Next-PC select: 1 = interrupt vector, 0 = in-line |
| bubble_o | output | 1 | Marks the dummy cycle |
| int_flag_o | output | 1 | Interrupt flag |

## Verification
A sleep request and an already-set interrupt flag can meet at the same cycle boundary. Sleep entry and wake then fall into one edge. The bench raises the flag first and then asserts sleep_req_i just before a boundary, with crystal mode selected. It passes only if the clock enable never drops and no start-up wait is seen. The vector select must also rise at that same boundary. A second overlap is a flag set and a flag clear in the same clock. The bench holds int_clr_i high across a pin edge and expects the flag to be seen set.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OST    = 3'd2,
    ST_RESUME = 3'd3,
    ST_BUBBLE = 3'd4
  } wake_state_e;
endpackage

// File: rtl/slp_q_phase.sv
module slp_q_phase #(
  parameter int PHASES = 4,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic          cyc_end_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign phase_o   = phase_q;
  assign cyc_end_o = (phase_q == LAST);
endmodule

// File: rtl/slp_int_flag.sv
module slp_int_flag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   rise;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      // set has priority over clear
      if (rise)       flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
  parameter int OST_CYCLES = 1024,
  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // saturates so done stays up until the next cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/slp_wake_fsm.sv
module slp_wake_fsm
  import slp_wake_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cyc_end_i,
  input  logic        sleep_req_i,
  input  logic        flag_i,
  input  logic        gie_i,
  input  logic        osc_xtal_i,
  input  logic        ost_done_i,
  output logic        ost_run_o,
  output wake_state_e state_o,
  output logic        gie_lat_o
);
  wake_state_e state_q, state_d;
  logic        gie_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (cyc_end_i && sleep_req_i) state_d = flag_i ? ST_RESUME : ST_SLEEP;
      ST_SLEEP:  if (cyc_end_i && flag_i)      state_d = osc_xtal_i ? ST_OST : ST_RESUME;
      ST_OST:    if (cyc_end_i && ost_done_i)  state_d = ST_RESUME;
      ST_RESUME: if (cyc_end_i)                state_d = gie_q ? ST_BUBBLE : ST_RUN;
      ST_BUBBLE: if (cyc_end_i)                state_d = ST_RUN;
      default:                                 state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_RESUME && state_q != ST_RESUME) gie_q <= gie_i;
    end
  end

  assign ost_run_o = (state_q == ST_OST);
  assign state_o   = state_q;
  assign gie_lat_o = gie_q;
endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
  import slp_wake_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int PHASES      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic int_pin_i,
  input  logic int_clr_i,
  input  logic gie_i,
  input  logic osc_xtal_i,
  output logic core_clk_en_o,
  output logic pc_vec_sel_o,
  output logic bubble_o,
  output logic int_flag_o
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [PW-1:0] phase;
  logic          cyc_end;
  logic          flag;
  logic          ost_run;
  logic          ost_done;
  logic          gie_lat;
  wake_state_e   state;

  slp_q_phase #(.PHASES(PHASES)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_o(phase), .cyc_end_o(cyc_end)
  );

  slp_int_flag #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(int_pin_i), .clr_i(int_clr_i), .flag_o(flag)
  );

  slp_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ost_run), .done_o(ost_done)
  );

  slp_wake_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_end_i(cyc_end), .sleep_req_i(sleep_req_i),
    .flag_i(flag), .gie_i(gie_i), .osc_xtal_i(osc_xtal_i), .ost_done_i(ost_done),
    .ost_run_o(ost_run), .state_o(state), .gie_lat_o(gie_lat)
  );

  assign core_clk_en_o = (state != ST_SLEEP) && (state != ST_OST);
  assign pc_vec_sel_o  = (state == ST_RESUME) && gie_lat;
  assign bubble_o      = (state == ST_BUBBLE);
  assign int_flag_o    = flag;
endmodule

// File: rtl/slp_wake_seq_chk.sv
module slp_wake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cyc_end,
  input logic sleep_req_i,
  input logic int_clr_i,
  input logic gie_i,
  input logic core_clk_en_o,
  input logic pc_vec_sel_o,
  input logic bubble_o,
  input logic int_flag_o
);
  AST_EDGE_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end |=> ($stable(core_clk_en_o) && $stable(pc_vec_sel_o) && $stable(bubble_o))); // R11

  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_flag_o && !int_clr_i) |=> int_flag_o); // R2

  AST_GATE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_clk_en_o) |-> ($past(sleep_req_i) && !$past(int_flag_o))); // R3

  AST_VEC_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pc_vec_sel_o) |-> $past(gie_i)); // R7

  AST_BUBBLE_AFTER_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pc_vec_sel_o) |-> bubble_o); // R8

  AST_BUBBLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (core_clk_en_o && !pc_vec_sel_o)); // R8
endmodule

bind slp_wake_seq slp_wake_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_end(cyc_end), .sleep_req_i(sleep_req_i),
  .int_clr_i(int_clr_i), .gie_i(gie_i), .core_clk_en_o(core_clk_en_o),
  .pc_vec_sel_o(pc_vec_sel_o), .bubble_o(bubble_o), .int_flag_o(int_flag_o)
);

// File: tb/slp_wake_seq_bench.sv
module slp_wake_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OST = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, int_pin = 1'b0, int_clr = 1'b0, gie = 1'b0, osc_xtal = 1'b0;
  logic clk_en, vec_sel, bubble, flag;
  int   ecnt = 0;
  int   checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  slp_wake_seq #(.OST_CYCLES(OST)) u_slp_wake_seq (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .int_pin_i(int_pin),
    .int_clr_i(int_clr), .gie_i(gie), .osc_xtal_i(osc_xtal),
    .core_clk_en_o(clk_en), .pc_vec_sel_o(vec_sel), .bubble_o(bubble), .int_flag_o(flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", req, ecnt, act, exp);
    end
  endtask

  // next posedge ends an instruction cycle
  task automatic to_pre_boundary();
    @(negedge clk);
    while (ecnt % 4 != 3) @(negedge clk);
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    @(negedge clk);
    while (!flag && n < 20) begin @(negedge clk); n++; end
    chk(req, flag, 1'b1);
  endtask

  task automatic clear_flag();
    int_pin = 1'b0;
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 clear", flag, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 clk_en", clk_en, 1'b1);
    chk("R1 vec_sel", vec_sel, 1'b0);
    chk("R1 bubble", bubble, 1'b0);
    chk("R1 flag", flag, 1'b0);
  endtask

  task automatic t_wake(input logic xtal, input logic g);
    int b;
    to_pre_boundary();
    sleep_req = 1'b1; osc_xtal = xtal; gie = g;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R3 gated", clk_en, 1'b0);
    repeat (9) @(negedge clk);
    chk("R4 stays asleep", clk_en, 1'b0);
    int_pin = 1'b1;
    wait_flag("R2 set");
    b = (ecnt / 4 + 1) * 4;
    while (ecnt < b - 1) @(negedge clk);
    chk("R4 no early wake", clk_en, 1'b0);
    if (xtal) begin
      @(negedge clk);
      chk("R5 wait starts", clk_en, 1'b0);
      while (ecnt < b + OST - 1) @(negedge clk);
      chk("R5 still gated", clk_en, 1'b0);
      @(negedge clk);
      chk("R5 release", clk_en, 1'b1);
    end else begin
      @(negedge clk);
      chk("R6 immediate", clk_en, 1'b1);
    end
    chk("R7 vec_sel", vec_sel, g);
    chk("R7 bubble", bubble, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 held", vec_sel, g);
    chk("R7 clk_en", clk_en, 1'b1);
    @(negedge clk);
    if (g) begin
      chk("R8 bubble", bubble, 1'b1);
      chk("R8 vec_sel", vec_sel, 1'b0);
      chk("R8 clk_en", clk_en, 1'b1);
      repeat (3) @(negedge clk);
      chk("R8 bubble held", bubble, 1'b1);
      @(negedge clk);
      chk("R8 one bubble", bubble, 1'b0);
    end else begin
      chk("R9 no bubble", bubble, 1'b0);
      chk("R9 in-line", vec_sel, 1'b0);
      chk("R9 running", clk_en, 1'b1);
    end
    clear_flag();
  endtask

  task automatic t_req_with_flag();
    int_pin = 1'b1;
    wait_flag("R10 flag");
    to_pre_boundary();
    sleep_req = 1'b1; osc_xtal = 1'b1; gie = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R10 no gate", clk_en, 1'b1);
    chk("R10 vectored", vec_sel, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 bubble", bubble, 1'b1);
    chk("R10 clk_en", clk_en, 1'b1);
    clear_flag();
  endtask

  task automatic t_flag_edges();
    int seen = 0;
    int_clr = 1'b1;
    @(negedge clk); int_pin = 1'b1;
    repeat (6) begin @(negedge clk); if (flag) seen = 1; end
    int_clr = 1'b0;
    chk("R2 set beats clear", seen[0], 1'b1);
    chk("R2 clear after", flag, 1'b0);
    int_pin = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 falling edge", flag, 1'b0);
  endtask

  task automatic t_phase_stable();
    int bad = 0;
    logic prev;
    to_pre_boundary();
    sleep_req = 1'b1; osc_xtal = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    prev = clk_en;
    repeat (3) begin @(negedge clk); if (clk_en !== prev) bad = 1; end
    chk("R11 stable in cycle", bad[0], 1'b0);
    int_pin = 1'b1;
    wait_flag("R11 flag");
    repeat (12) @(negedge clk);
    clear_flag();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wake(1'b0, 1'b1);
    t_wake(1'b0, 1'b0);
    t_wake(1'b1, 1'b1);
    t_wake(1'b1, 1'b0);
    t_req_with_flag();
    t_flag_edges();
    t_phase_stable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule